// File: doc/BRIEF.md
# Link Token Ownership Arbiter

This block decides which of the two ends of a point-to-point, half-duplex parallel link may drive data. A single token grants the right to transmit. The end configured as master holds the token when it comes out of reset, and the other end starts without it. Direction changes in-band. The holder sends a programmable release word as an ordinary data value and then gives up its token. The far end compares every word it receives against the same release word, and takes the token when a word matches.

On the local side, a transmit word port uses valid/ready and a receive word port uses valid only. Two configuration inputs set the release word and the reset-time role. A request input starts a hand-over, and a status output shows whether this end holds the token. The link side is a plain word bus with a valid strobe in each direction. The link is assumed to take every word it is offered, and pin timing and FIFOs lie outside the block.

Top module: `link_token_arbiter`

## Requirements
- R1: After a synchronous active-low reset, `token_held` equals `cfg_is_master` (1 means master, which holds the token).
- R2: While `token_held` is 0, `tx_ready` and `link_tx_valid` are both 0, whatever `tx_valid` is.
- R3: While the token is held and no release is pending, `tx_ready` is 1. A word with `tx_valid` high appears on `link_tx_data` with `link_tx_valid` in the same cycle.
- R4: When `release_req` is seen high at a clock edge while the token is held, the next cycle drives `cfg_release_word` on the link with `link_tx_valid` high and `tx_ready` low.
- R5: In the cycle after the release word is sent, `token_held` is 0 and no further word is sent on the link.
- R6: `release_req` is ignored while the token is not held. The token stays clear and nothing is sent.
- R7: While the token is not held, a received word equal to `cfg_release_word` on all W bits is not forwarded (`rx_valid` stays 0), and `token_held` is 1 from the next cycle.
- R8: A received word that is not equal to the release word, including one that differs in a single bit, is forwarded on `rx_data` with `rx_valid` in the same cycle, and the token state does not change.
- R9: While the token is held, a received word equal to the release word is forwarded as data, and the token stays held.
- R10: A synchronous reset applied in the middle of operation restores the role-based token state and clears any pending release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_is_master | input | 1 | Role at reset: 1 = starts with the token |
| cfg_release_word | input | W | Hand-over word value |
| release_req | input | 1 | Request to give up the token |
| tx_data | input | W | Local word to send |
| tx_valid | input | 1 | Local word present |
| tx_ready | output | 1 | Local word accepted this cycle |
| link_tx_data | output | W | Word driven onto the link |
| link_tx_valid | output | 1 | Link word valid |
| link_rx_data | input | W | Word received from the link |
| link_rx_valid | input | 1 | Received word valid |
| rx_data | output | W | Forwarded received word |
| rx_valid | output | 1 | Forwarded word valid |
| token_held | output | 1 | This end owns the link |

## Verification
The assertions assume three things: `cfg_release_word` stays constant between resets, the link accepts every word offered, and the far end sends nothing while this end is releasing. The bench changes the configuration only while reset is asserted. It applies received words only in cycles where no release is pending, and it samples every output between clock edges after the inputs have settled.

// File: rtl/lta_pkg.sv
// Shared types for the link token arbiter.
// Assumes: none beyond a single clock domain.
package lta_pkg;
    // Token ownership state held by the control register.
    typedef struct packed {
        logic held;     // this end owns the link
        logic pending;  // release word is being sent this cycle
    } tok_state_t;
endpackage

// File: rtl/lta_token_ctrl.sv
// Token ownership state machine: role-based reset, hand-over sequencing and take-over.
// Assumes: rx_take is asserted only while the token is not held.
module lta_token_ctrl
    import lta_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic role_master,
    input  logic release_req,
    input  logic release_sent,
    input  logic rx_take,
    output logic held,
    output logic pending
);
    tok_state_t st_q;

    // Update ownership: take-over, completion of release, or arming a release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.held    <= role_master;
            st_q.pending <= 1'b0;
        end else if (rx_take) begin
            st_q.held    <= 1'b1;
        end else if (release_sent) begin
            st_q.held    <= 1'b0;
            st_q.pending <= 1'b0;
        end else if (release_req && st_q.held && !st_q.pending) begin
            st_q.pending <= 1'b1;
        end
    end

    assign held    = st_q.held;
    assign pending = st_q.pending;

    assert_release_drops_token_R5: assert property (@(posedge clk) disable iff (!rst_n)
        release_sent |=> !held);
    assert_idle_req_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!held && !rx_take) |=> (!held && !pending));
    assert_pending_needs_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> held);
endmodule

// File: rtl/lta_tx_path.sv
// Transmit path: chooses between the local word and the release word, and applies the token gate.
// Assumes: the link accepts every word presented with valid.
module lta_tx_path #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         held,
    input  logic         pending,
    input  logic [W-1:0] release_word,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic [W-1:0] link_data,
    output logic         link_valid,
    output logic         release_sent
);
    // Select the outgoing word; the release word has priority over local data.
    always_comb begin
        tx_ready     = held && !pending;
        release_sent = held && pending;
        link_valid   = release_sent || (tx_ready && tx_valid);
        link_data    = pending ? release_word : tx_data;
    end

    assert_no_tx_without_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !held |-> (!link_valid && !tx_ready));
    assert_release_blocks_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> (!tx_ready && link_data == release_word));
endmodule

// File: rtl/lta_rx_filter.sv
// Receive filter: detects the release word while not holding the token and removes it from the data stream.
// Assumes: the comparison is made on all W bits.
module lta_rx_filter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         held,
    input  logic [W-1:0] release_word,
    input  logic [W-1:0] in_data,
    input  logic         in_valid,
    output logic [W-1:0] out_data,
    output logic         out_valid,
    output logic         take
);
    logic hit;

    // Compare the full word and suppress a matching word while waiting for the token.
    always_comb begin
        hit       = (in_data == release_word);
        take      = in_valid && hit && !held;
        out_valid = in_valid && !take;
        out_data  = in_data;
    end

    assert_take_sets_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> held);
    assert_holder_forwards_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (held && in_valid) |-> out_valid);
endmodule

// File: rtl/link_token_arbiter.sv
// Top level: token-based direction control for a half-duplex word link.
// Assumes: cfg_release_word is stable between resets; cfg_is_master is sampled during reset.
module link_token_arbiter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cfg_is_master,
    input  logic [W-1:0] cfg_release_word,
    input  logic         release_req,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic [W-1:0] link_tx_data,
    output logic         link_tx_valid,
    input  logic [W-1:0] link_rx_data,
    input  logic         link_rx_valid,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         token_held
);
    logic held, pending, release_sent, rx_take;

    lta_token_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .role_master(cfg_is_master),
        .release_req(release_req), .release_sent(release_sent), .rx_take(rx_take),
        .held(held), .pending(pending)
    );

    lta_tx_path #(.W(W)) u_tx (
        .clk(clk), .rst_n(rst_n), .held(held), .pending(pending),
        .release_word(cfg_release_word), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .link_data(link_tx_data), .link_valid(link_tx_valid),
        .release_sent(release_sent)
    );

    lta_rx_filter #(.W(W)) u_rx (
        .clk(clk), .rst_n(rst_n), .held(held), .release_word(cfg_release_word),
        .in_data(link_rx_data), .in_valid(link_rx_valid),
        .out_data(rx_data), .out_valid(rx_valid), .take(rx_take)
    );

    assign token_held = held;

    assert_accept_drives_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |-> (link_tx_valid && link_tx_data == tx_data));
    assert_mismatch_forwarded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_rx_valid && link_rx_data != cfg_release_word) |-> (rx_valid && rx_data == link_rx_data));
    assert_release_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (release_req && token_held && !pending && !rx_take) |=> (link_tx_valid && !tx_ready));
endmodule

// File: tb/sim_link_token_arbiter.sv
module sim_link_token_arbiter;
    localparam int unsigned W = 16;
    localparam logic [W-1:0] REL = 16'hC3E1;

    logic clk = 0;
    logic rst_n = 0;
    logic cfg_is_master = 1;
    logic [W-1:0] cfg_release_word = REL;
    logic release_req = 0;
    logic [W-1:0] tx_data = '0;
    logic tx_valid = 0;
    logic tx_ready;
    logic [W-1:0] link_tx_data;
    logic link_tx_valid;
    logic [W-1:0] link_rx_data = '0;
    logic link_rx_valid = 0;
    logic [W-1:0] rx_data;
    logic rx_valid;
    logic token_held;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    link_token_arbiter #(.W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_is_master(cfg_is_master),
        .cfg_release_word(cfg_release_word), .release_req(release_req),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .link_tx_data(link_tx_data), .link_tx_valid(link_tx_valid),
        .link_rx_data(link_rx_data), .link_rx_valid(link_rx_valid),
        .rx_data(rx_data), .rx_valid(rx_valid), .token_held(token_held)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Advance to just after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic role);
        rst_n = 0; cfg_is_master = role;
        release_req = 0; tx_valid = 0; link_rx_valid = 0;
        tick();
        rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        check("R1 master token", token_held, 1);
        do_reset(1'b0);
        check("R1 slave token", token_held, 0);
        tx_valid = 1; tx_data = 16'h1234; #2;
        check("R2 no ready", tx_ready, 0);
        check("R2 no link valid", link_tx_valid, 0);
        tick();
        check("R2 still no link valid", link_tx_valid, 0);
        tx_valid = 0;
    endtask

    task automatic t_send();
        do_reset(1'b1);
        tx_valid = 1; tx_data = 16'hA55A; #2;
        check("R3 ready", tx_ready, 1);
        check("R3 link valid", link_tx_valid, 1);
        check("R3 link data", link_tx_data, 16'hA55A);
        tick();
        tx_data = 16'h0F0F; #2;
        check("R3 second word", link_tx_data, 16'h0F0F);
        tx_valid = 0; #1;
        check("R3 idle", link_tx_valid, 0);
    endtask

    task automatic t_release();
        do_reset(1'b1);
        release_req = 1; tx_valid = 1; tx_data = 16'h7777;
        tick();
        release_req = 0; #1;
        check("R4 release valid", link_tx_valid, 1);
        check("R4 release data", link_tx_data, REL);
        check("R4 ready low", tx_ready, 0);
        tick();
        check("R5 token dropped", token_held, 0);
        check("R5 no word after", link_tx_valid, 0);
        tick();
        check("R5 still quiet", link_tx_valid, 0);
        tx_valid = 0;
    endtask

    task automatic t_ignore();
        do_reset(1'b0);
        release_req = 1; tx_valid = 1;
        tick(); tick();
        check("R6 token stays clear", token_held, 0);
        check("R6 nothing sent", link_tx_valid, 0);
        release_req = 0; tx_valid = 0;
    endtask

    task automatic t_take();
        do_reset(1'b0);
        link_rx_valid = 1; link_rx_data = REL; #2;
        check("R7 match not forwarded", rx_valid, 0);
        tick();
        link_rx_valid = 0; #1;
        check("R7 token taken", token_held, 1);
        tx_valid = 1; tx_data = 16'hBEEF; #1;
        check("R7 can transmit", link_tx_valid, 1);
        tx_valid = 0;
    endtask

    task automatic t_fwd();
        do_reset(1'b0);
        link_rx_valid = 1; link_rx_data = REL ^ 16'h0001; #2;
        check("R8 lsb diff forwarded", rx_valid, 1);
        check("R8 data", rx_data, REL ^ 16'h0001);
        tick();
        link_rx_data = REL ^ 16'h8000; #2;
        check("R8 msb diff forwarded", rx_valid, 1);
        check("R8 token unchanged", token_held, 0);
        tick();
        link_rx_valid = 0; #1;
        check("R8 token still clear", token_held, 0);
    endtask

    task automatic t_holder_rx();
        do_reset(1'b1);
        link_rx_valid = 1; link_rx_data = REL; #2;
        check("R9 forwarded at holder", rx_valid, 1);
        check("R9 data", rx_data, REL);
        tick();
        link_rx_valid = 0; #1;
        check("R9 token kept", token_held, 1);
    endtask

    task automatic t_midreset();
        do_reset(1'b1);
        release_req = 1;
        tick();
        release_req = 0;
        tick();
        check("R10 released before reset", token_held, 0);
        do_reset(1'b1);
        check("R10 master restored", token_held, 1);
        release_req = 1;
        tick();
        release_req = 0;
        do_reset(1'b1);
        #1;
        check("R10 pending cleared", link_tx_valid, 0);
        check("R10 token after clear", token_held, 1);
        do_reset(1'b0);
        link_rx_valid = 1; link_rx_data = REL;
        tick();
        link_rx_valid = 0;
        do_reset(1'b0);
        check("R10 slave restored", token_held, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_send();
        t_release();
        t_ignore();
        t_take();
        t_fwd();
        t_holder_rx();
        t_midreset();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule